// File: doc/BRIEF.md
# Lockable SMM Memory Window Controller

This block sits beside a host bridge and guards one fixed 128 KiB stretch of low memory, starting at 0x30000, on behalf of the processor's system management mode (SMM). It holds a single byte-wide feature register in configuration space at offset 0x9C. For every memory access it decides one of two outcomes. Either the access goes on to the backing RAM, or it is swallowed: a swallowed read returns all ones and a swallowed write is dropped.

Firmware discovers and arms the feature with a two-step handshake. First it writes the query value 0xFF. If the feature is present, the register then reads 0x01 and only bit 1 stays writable. Firmware then installs its handler in the window from normal mode and sets bit 1. After that the register reads 0x02, ignores every write until reset, and hides the window from all non-SMM accesses. A configuration-time enable input removes the feature completely.

The control path is a three-state machine, and the register value and write mask are decoded from the state:
- **OPEN**: the reset state. The register reads 0x00, all bits are writable, and the window is plain RAM.
- **ARMED**: the query has succeeded. The register reads 0x01, only bit 1 is writable, and the window is plain RAM.
- **LOCKED**: the register reads 0x02, nothing is writable, and non-SMM accesses are swallowed.

The transitions are:
- **query**: OPEN to ARMED, on a write of 0xFF to the register's byte lane while the feature is enabled.
- **discard**: OPEN to OPEN, on any other write.
- **keep**: ARMED to ARMED, on a write whose masked bit 1 is clear.
- **arm_lock**: ARMED to LOCKED, on a write with bit 1 set.
- **hold**: LOCKED to LOCKED, on any write.
- **reset**: any state to OPEN.

Top module: `smm_window_ctrl`

## Requirements
- R1: After reset the register at offset 0x9C reads 0x00 (byte lane 0 of the dword at 0x9C; the other lanes read 0), and a non-SMM access to the window reaches RAM.
- R2: With the feature enabled, writing 0xFF to the register in the OPEN state makes it read 0x01.
- R3: In the OPEN state, a write of any value other than 0xFF is discarded: the register still reads 0x00 and the window is not hidden.
- R4: In the ARMED state, a write with bit 1 (0x02) set locks the window, and the register reads 0x02.
- R5: In the ARMED state only bit 1 is writable: a write with bit 1 clear (for example 0xFD) leaves the register at 0x01.
- R6: Once locked, every register write is ignored (the register keeps reading 0x02) until reset, and reset returns it to 0x00 with the window open.
- R7: While locked, a non-SMM read or write to the window is swallowed: mem_blackhole=1, mem_to_ram=0, and mem_bh_rdata is all ones over the requested width (mem_size = bytes-1, lane 0 upward), with zeros above it.
- R8: While locked, SMM accesses to the window reach RAM.
- R9: Before lock, every access to the window reaches RAM, whatever the mode.
- R10: With feat_en low, register writes have no effect (reads stay 0x00) and the window is never hidden.
- R11: The window is the address range 0x30000 to 0x4FFFF inclusive. Both end addresses are hidden when locked, and 0x2FFFF and 0x50000 always pass to RAM.
- R12: A configuration write updates the register only from byte lane 0 of the dword at 0x9C, and only when cfg_be[0] is set. Writes to other lanes or dwords have no effect, and a full-dword write acts on lane 0 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_en | input | 1 | Configuration-time feature enable, held static out of reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address; the low 2 bits are ignored |
| cfg_be | input | 4 | Byte enables of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for the dword at cfg_addr |
| mem_valid | input | 1 | Memory access present |
| mem_addr | input | 32 | Memory access byte address |
| mem_write | input | 1 | 1 for a write, 0 for a read |
| mem_smm | input | 1 | Access issued in SMM |
| mem_size | input | 2 | Access width in bytes minus one |
| mem_to_ram | output | 1 | Route the access to RAM |
| mem_blackhole | output | 1 | Swallow the access |
| mem_bh_rdata | output | 32 | Read data returned for a swallowed access |

## Verification
The embedded properties check several rules on every cycle. LOCKED never leaves except through reset. ARMED is entered only from a 0xFF write on the register lane, and LOCKED only from ARMED. A disabled feature keeps the machine in OPEN. On the access side, SMM accesses and accesses below the window base are never swallowed, route and blackhole are never both raised, and nothing is hidden before lock. The stimulus scenarios are what show the values the register reads back after each handshake step. They also show the exact all-ones width for each access size, the boundary addresses at both ends, the byte-lane selection of wide writes, and that reset undoes a lock.

// File: rtl/smw_pkg.sv
package smw_pkg;

    typedef enum logic [1:0] {
        ST_OPEN   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_LOCKED = 2'd2
    } win_state_e;

    localparam logic [7:0] CODE_QUERY  = 8'hFF;
    localparam logic [7:0] CODE_AVAIL  = 8'h01;
    localparam logic [7:0] CODE_LOCKED = 8'h02;
    localparam int         LOCK_BIT    = 1;

endpackage

// File: rtl/smw_cfg_lane.sv
module smw_cfg_lane #(
    parameter int CFG_AW    = 8,
    parameter int BUS_BYTES = 4,
    parameter int REG_OFF   = 'h9C
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [BUS_BYTES-1:0]   cfg_be,
    input  logic [BUS_BYTES*8-1:0] cfg_wdata,
    input  logic [7:0]             reg_byte,
    output logic                   hit_wr,
    output logic [7:0]             wr_byte,
    output logic [BUS_BYTES*8-1:0] cfg_rdata
);
    localparam int LB     = $clog2(BUS_BYTES);
    localparam int LANE   = REG_OFF % BUS_BYTES;
    localparam int DW_IDX = REG_OFF / BUS_BYTES;

    logic dw_sel;

    // Only the dword index matters; the lane comes from the byte enables.
    assign dw_sel  = (32'(cfg_addr[CFG_AW-1:LB]) == 32'(DW_IDX));
    assign hit_wr  = cfg_we && dw_sel && cfg_be[LANE];
    assign wr_byte = cfg_wdata[LANE*8 +: 8];

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_rd_lane
        if (i == LANE) begin : g_reg
            assign cfg_rdata[i*8 +: 8] = dw_sel ? reg_byte : 8'h00;
        end else begin : g_zero
            assign cfg_rdata[i*8 +: 8] = 8'h00;
        end
    end

    // R12: a register update is only ever requested with its own lane enabled
    a_r12_lane_enable: assert property (@(posedge clk) disable iff (!rst_n)
        hit_wr |-> (cfg_we && cfg_be[LANE]));

endmodule

// File: rtl/smw_fsm.sv
module smw_fsm
    import smw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       feat_en,
    input  logic       hit_wr,
    input  logic [7:0] wr_byte,
    output logic [7:0] reg_byte,
    output logic       locked
);
    win_state_e state_q, state_d;
    logic [7:0] wmask;
    logic [7:0] merged;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // outputs decoded from state: value, write mask, lock flag
    always_comb begin
        reg_byte = 8'h00;
        wmask    = 8'h00;
        locked   = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                reg_byte = 8'h00;
                wmask    = 8'hFF;
            end
            ST_ARMED: begin
                reg_byte = CODE_AVAIL;
                wmask    = CODE_LOCKED;
            end
            ST_LOCKED: begin
                reg_byte = CODE_LOCKED;
                wmask    = 8'h00;
                locked   = 1'b1;
            end
            default: begin
                reg_byte = 8'h00;
                wmask    = 8'h00;
            end
        endcase
    end

    assign merged = (reg_byte & ~wmask) | (wr_byte & wmask);

    // transitions: query, discard, keep, arm_lock, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (hit_wr && feat_en && (merged == CODE_QUERY))
                    state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (hit_wr && merged[LOCK_BIT])
                    state_d = ST_LOCKED;
            end
            ST_LOCKED: state_d = ST_LOCKED;
            default:   state_d = ST_OPEN;
        endcase
    end

    // R6: lock is sticky until reset
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED) |=> (state_q == ST_LOCKED));

    // R2: arming needs a query write on the register lane
    a_r2_arm_on_query: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_ARMED) |-> $past(hit_wr && (wr_byte == CODE_QUERY)));

    // R4: locking only follows a successful query
    a_r4_lock_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_LOCKED) |-> ($past(state_q) == ST_ARMED));

    // R10: a disabled feature never leaves the open state
    a_r10_disabled_open: assert property (@(posedge clk) disable iff (!rst_n)
        !feat_en |-> (state_q == ST_OPEN));

endmodule

// File: rtl/smw_gate.sv
module smw_gate #(
    parameter int              ADDR_W    = 32,
    parameter int              BUS_BYTES = 4,
    parameter logic [31:0]     WIN_BASE  = 32'h0003_0000,
    parameter int              WIN_BYTES = 128 * 1024
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   locked,
    input  logic                   mem_valid,
    input  logic [ADDR_W-1:0]      mem_addr,
    input  logic                   mem_write,
    input  logic                   mem_smm,
    input  logic [1:0]             mem_size,
    output logic                   mem_to_ram,
    output logic                   mem_blackhole,
    output logic [BUS_BYTES*8-1:0] mem_bh_rdata
);
    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(WIN_BASE);
    localparam logic [ADDR_W:0] HI = LO + (ADDR_W+1)'(WIN_BYTES);

    logic in_win;
    logic hide;
    logic unused_wr;

    assign in_win = ({1'b0, mem_addr} >= LO) && ({1'b0, mem_addr} < HI);
    assign hide   = locked && in_win && !mem_smm;

    // reads and writes are swallowed alike; direction does not alter routing
    assign unused_wr     = mem_write;
    assign mem_blackhole = mem_valid && hide;
    assign mem_to_ram    = mem_valid && !hide;

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_bh_lane
        assign mem_bh_rdata[i*8 +: 8] =
            (mem_blackhole && (32'(mem_size) >= i)) ? 8'hFF : 8'h00;
    end

    // R8: SMM accesses are never swallowed
    a_r8_smm_reaches_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_smm) |-> (mem_to_ram && !mem_blackhole));

    // R9: before lock nothing is hidden
    a_r9_open_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !locked) |-> mem_to_ram);

    // R11: addresses below the base pass through
    a_r11_below_base: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && ({1'b0, mem_addr} < LO)) |-> !mem_blackhole);

    // R7: an access has at most one destination
    a_r7_one_route: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_to_ram, mem_blackhole}));

endmodule

// File: rtl/smm_window_ctrl.sv
module smm_window_ctrl #(
    parameter int          CFG_AW    = 8,
    parameter int          BUS_BYTES = 4,
    parameter int          ADDR_W    = 32,
    parameter int          REG_OFF   = 'h9C,
    parameter logic [31:0] WIN_BASE  = 32'h0003_0000,
    parameter int          WIN_BYTES = 128 * 1024
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   feat_en,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [BUS_BYTES-1:0]   cfg_be,
    input  logic [BUS_BYTES*8-1:0] cfg_wdata,
    output logic [BUS_BYTES*8-1:0] cfg_rdata,
    input  logic                   mem_valid,
    input  logic [ADDR_W-1:0]      mem_addr,
    input  logic                   mem_write,
    input  logic                   mem_smm,
    input  logic [1:0]             mem_size,
    output logic                   mem_to_ram,
    output logic                   mem_blackhole,
    output logic [BUS_BYTES*8-1:0] mem_bh_rdata
);
    logic       hit_wr;
    logic [7:0] wr_byte;
    logic [7:0] reg_byte;
    logic       locked;

    smw_cfg_lane #(
        .CFG_AW    (CFG_AW),
        .BUS_BYTES (BUS_BYTES),
        .REG_OFF   (REG_OFF)
    ) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .reg_byte  (reg_byte),
        .hit_wr    (hit_wr),
        .wr_byte   (wr_byte),
        .cfg_rdata (cfg_rdata)
    );

    smw_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .feat_en  (feat_en),
        .hit_wr   (hit_wr),
        .wr_byte  (wr_byte),
        .reg_byte (reg_byte),
        .locked   (locked)
    );

    smw_gate #(
        .ADDR_W    (ADDR_W),
        .BUS_BYTES (BUS_BYTES),
        .WIN_BASE  (WIN_BASE),
        .WIN_BYTES (WIN_BYTES)
    ) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .locked        (locked),
        .mem_valid     (mem_valid),
        .mem_addr      (mem_addr),
        .mem_write     (mem_write),
        .mem_smm       (mem_smm),
        .mem_size      (mem_size),
        .mem_to_ram    (mem_to_ram),
        .mem_blackhole (mem_blackhole),
        .mem_bh_rdata  (mem_bh_rdata)
    );

endmodule

// File: tb/sim_smm_window_ctrl.sv
module sim_smm_window_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        feat_en = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_addr = 32'h0;
    logic        mem_write = 1'b0;
    logic        mem_smm = 1'b0;
    logic [1:0]  mem_size = 2'd0;
    logic        mem_to_ram;
    logic        mem_blackhole;
    logic [31:0] mem_bh_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    smm_window_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .feat_en(feat_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_write(mem_write),
        .mem_smm(mem_smm), .mem_size(mem_size),
        .mem_to_ram(mem_to_ram), .mem_blackhole(mem_blackhole),
        .mem_bh_rdata(mem_bh_rdata)
    );

    // op: 0 config write, 1 config read check, 2 memory access check
    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        logic        smm;
        logic        wr;
        logic [1:0]  sz;
        logic [31:0] exp;
        logic        exp_bh;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 32'h9C,    32'h0,        4'h0, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 4'd1},  // R1
        '{2'd2, 32'h30000, 32'h0,        4'h0, 1'b0, 1'b0, 2'd3, 32'h0,        1'b0, 4'd1},  // R1
        '{2'd0, 32'h9C,    32'h2,        4'h1, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 4'd3},  // R3
        '{2'd1, 32'h9C,    32'h0,        4'h0, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 4'd3},  // R3
        '{2'd0, 32'h9C,    32'h0000FF00, 4'h2, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 4'd12}, // R12 wrong lane
        '{2'd1, 32'h9C,    32'h0,        4'h0, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 4'd12}, // R12
        '{2'd0, 32'h98,    32'h000000FF, 4'hF, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 4'd12}, // R12 wrong dword
        '{2'd1, 32'h9C,    32'h0,        4'h0, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 4'd12}, // R12
        '{2'd0, 32'h9C,    32'h020202FF, 4'hF, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 4'd2},  // R2 via wide write
        '{2'd1, 32'h9C,    32'h0,        4'h0, 1'b0, 1'b0, 2'd0, 32'h1,        1'b0, 4'd2},  // R2
        '{2'd0, 32'h9C,    32'hFD,       4'h1, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 4'd5},  // R5
        '{2'd1, 32'h9C,    32'h0,        4'h0, 1'b0, 1'b0, 2'd0, 32'h1,        1'b0, 4'd5},  // R5
        '{2'd2, 32'h30000, 32'h0,        4'h0, 1'b0, 1'b0, 2'd3, 32'h0,        1'b0, 4'd9},  // R9
        '{2'd0, 32'h9C,    32'h2,        4'h1, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 4'd4},  // R4
        '{2'd1, 32'h9C,    32'h0,        4'h0, 1'b0, 1'b0, 2'd0, 32'h2,        1'b0, 4'd4},  // R4
        '{2'd0, 32'h9C,    32'hFF,       4'hF, 1'b0, 1'b0, 2'd0, 32'h0,        1'b0, 4'd6},  // R6
        '{2'd1, 32'h9C,    32'h0,        4'h0, 1'b0, 1'b0, 2'd0, 32'h2,        1'b0, 4'd6},  // R6
        '{2'd2, 32'h30000, 32'h0,        4'h0, 1'b0, 1'b0, 2'd0, 32'h000000FF, 1'b1, 4'd7},  // R7 byte
        '{2'd2, 32'h4FFFF, 32'h0,        4'h0, 1'b0, 1'b0, 2'd1, 32'h0000FFFF, 1'b1, 4'd11}, // R11 top
        '{2'd2, 32'h40000, 32'h0,        4'h0, 1'b0, 1'b0, 2'd3, 32'hFFFFFFFF, 1'b1, 4'd7},  // R7 dword
        '{2'd2, 32'h2FFFF, 32'h0,        4'h0, 1'b0, 1'b0, 2'd3, 32'h0,        1'b0, 4'd11}, // R11 below
        '{2'd2, 32'h50000, 32'h0,        4'h0, 1'b0, 1'b0, 2'd3, 32'h0,        1'b0, 4'd11}, // R11 above
        '{2'd2, 32'h30000, 32'h0,        4'h0, 1'b1, 1'b0, 2'd3, 32'h0,        1'b0, 4'd8},  // R8 read
        '{2'd2, 32'h31000, 32'h0,        4'h0, 1'b1, 1'b1, 2'd3, 32'h0,        1'b0, 4'd8},  // R8 write
        '{2'd2, 32'h31000, 32'h0,        4'h0, 1'b0, 1'b1, 2'd2, 32'h00FFFFFF, 1'b1, 4'd7}   // R7 write
    };

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_be = be; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic cfg_check(input logic [7:0] a, input logic [31:0] exp, input int req);
        @(negedge clk);
        cfg_addr = a;
        #2;
        checks++;
        if (cfg_rdata !== exp) begin
            errors++;
            $display("FAIL R%0d cfg_rdata actual=%h expected=%h", req, cfg_rdata, exp);
        end
    endtask

    task automatic mem_check(input logic [31:0] a, input logic smm, input logic wr,
                             input logic [1:0] sz, input logic exp_bh,
                             input logic [31:0] exp_d, input int req);
        @(negedge clk);
        mem_valid = 1'b1; mem_addr = a; mem_smm = smm; mem_write = wr; mem_size = sz;
        #2;
        checks++;
        if (mem_blackhole !== exp_bh || mem_to_ram !== !exp_bh || mem_bh_rdata !== exp_d) begin
            errors++;
            $display("FAIL R%0d mem bh/ram/data actual=%b/%b/%h expected=%b/%b/%h",
                     req, mem_blackhole, mem_to_ram, mem_bh_rdata, exp_bh, !exp_bh, exp_d);
        end
        @(negedge clk);
        mem_valid = 1'b0;
    endtask

    task automatic do_reset(input logic en);
        @(negedge clk);
        rst_n = 1'b0;
        feat_en = en;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset(1'b1);
        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].op)
                2'd0: cfg_write(VECS[i].addr[7:0], VECS[i].data, VECS[i].be);
                2'd1: cfg_check(VECS[i].addr[7:0], VECS[i].exp, int'(VECS[i].req));
                default: mem_check(VECS[i].addr, VECS[i].smm, VECS[i].wr, VECS[i].sz,
                                   VECS[i].exp_bh, VECS[i].exp, int'(VECS[i].req));
            endcase
        end

        // R6: reset clears a lock
        do_reset(1'b1);
        cfg_check(8'h9C, 32'h0, 6);
        mem_check(32'h30000, 1'b0, 1'b0, 2'd3, 1'b0, 32'h0, 6);

        // R3: lock value without query does not lock
        cfg_write(8'h9C, 32'h2, 4'h1);
        cfg_check(8'h9C, 32'h0, 3);
        mem_check(32'h30000, 1'b0, 1'b0, 2'd3, 1'b0, 32'h0, 3);

        // R10: feature disabled by configuration
        do_reset(1'b0);
        cfg_write(8'h9C, 32'hFF, 4'h1);
        cfg_check(8'h9C, 32'h0, 10);
        cfg_write(8'h9C, 32'h2, 4'h1);
        cfg_check(8'h9C, 32'h0, 10);
        mem_check(32'h30000, 1'b0, 1'b0, 2'd3, 1'b0, 32'h0, 10);

        // R1: reset state with feature on, checked fresh
        do_reset(1'b1);
        cfg_check(8'h9C, 32'h0, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule